// File: doc/BRIEF.md
# Cascaded 16-bit Capture Timer

This block is a 16-bit up-counter made from two chained 8-bit halves. It counts ticks from one of seven power-of-two divisions of the system clock, or from rising edges of an external clock pin. A 16-bit compare value sets the counting period. When the running count equals the compare value on a tick, the counter returns to zero and a timer flag is raised.

A second input, the event pin, is synchronized and edge-detected. On the chosen edge, the current count is copied into a pair of 8-bit capture registers and a capture flag is raised. Software can use this to timestamp external events or to measure pulse widths.

Software reaches the block through a plain write-enable/address register port with combinational read data. Both flags stay set until software clears them by writing a 1.

Top module: `cap_timer16`

## Requirements
- R1: After the asynchronous reset, every register reads 0 and both interrupt outputs are low.
- R2: The count advances by one per selected tick only while all of these hold: the run bit (address 0, bit 4) is 1, the cascade bit (address 1, bit 0) is 1, and both high-half select bits (address 1, bits 2:1) are 1. In every other case the count holds its value. The count low byte reads at address 6 and the high byte at address 7.
- R3: Clock select (address 0, bits 2:0) values 0 to 6 pick a divide-by-2, 4, 8, 32, 128, 512 or 2048 tick. The tick fires when the low log2(N) bits of a free-running divider, which starts at zero at reset, are all ones. Value 7 picks a rising edge of the external clock pin, taken after a two-flop synchronizer.
- R4: Writing address 0 with bit 3 set zeroes the count in that cycle, and this takes priority over a tick. Bit 3 is not stored and always reads 0.
- R5: Edge select (address 1, bits 4:3) works as follows: 00 is the falling edge, 01 the rising edge, 10 both edges, 11 no capture. The event pin passes through two synchronizer flops. On the selected edge, the count present in that cycle is copied into address 4 (low byte) and address 5 (high byte), and the capture flag is raised. At all other times the capture registers hold.
- R6: On a counting tick where the count equals the compare value (address 2 low byte, address 3 high byte), the count becomes 0 on that tick and the timer flag is raised. A clear on the same write suppresses this.
- R7: A write to address 6 clears the timer flag when bit 0 is set and the capture flag when bit 1 is set. A flag that is set and cleared in the same cycle stays set. `tmr_irq_o` and `cap_irq_o` show the two flags.
- R8: Addresses 0 to 3 read back their stored fields with the unused bits as 0. Writes to addresses 4, 5 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| int_pin_i | input | 1 | Capture event pin, asynchronous |
| tmr_irq_o | output | 1 | Timer (compare) flag |
| cap_irq_o | output | 1 | Capture flag |

## Verification
Two collisions are of interest. The first is a flag being raised in the very cycle software writes 1 to clear it. The second is a counter clear landing in the same cycle as a compare-match tick. The bench provokes both by setting a tiny compare value at the divide-by-2 tick and issuing clear writes back to back, so these writes collide with wraps and with captures driven by a randomly toggling event pin. A behavioural model steps alongside the design. Every cycle it is compared against both flag outputs and against a rotating register read, so a clear that wins over a set, or a clear that fails to beat a match, shows up one cycle later.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL_LO = 3'd0,
    A_CTRL_HI = 3'd1,
    A_CMP_LO  = 3'd2,
    A_CMP_HI  = 3'd3,
    A_CAP_LO  = 3'd4,
    A_CAP_HI  = 3'd5,
    A_CNT_LO  = 3'd6,
    A_CNT_HI  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic       run;
    logic [2:0] clk_sel;
  } ctrl_lo_t;

  typedef struct packed {
    edge_sel_e  edge_sel;
    logic [1:0] hi_sel;
    logic       cascade;
  } ctrl_hi_t;
endpackage

// File: rtl/cap_timer16_edge.sv
module cap_timer16_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_fall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cap_timer16_clksel.sv
module cap_timer16_clksel #(
  parameter int unsigned DIV_W = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_rise_i,
  output logic       tick_o
);
  localparam int unsigned N_TAPS = 7;
  localparam int unsigned TAP_LOG2 [N_TAPS] = '{1, 2, 3, 5, 7, 9, 11};

  logic [DIV_W-1:0]  div_q;
  logic [N_TAPS-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign taps[g] = &div_q[TAP_LOG2[g]-1:0];
  end

  always_comb begin
    if (sel_i == 3'd7) tick_o = ext_rise_i;
    else               tick_o = taps[sel_i];
  end

  // every internal tap fires on an odd divider value
  p_tick_odd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 3'd7 && tick_o) |-> div_q[0]);
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 3'd7 && tick_o) |=> !taps[0]);
endmodule

// File: rtl/cap_timer16_cnt.sv
module cap_timer16_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit = (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign match_o = tick_i & ~clr_i & hit;

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i && cnt_q != cmp_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i && cnt_q == cmp_i) |=> cnt_q == '0);
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import cap_timer16_pkg::*;
#(
  parameter int unsigned DIV_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_clk_i,
  input  logic              int_pin_i,
  output logic              tmr_irq_o,
  output logic              cap_irq_o
);
  localparam int unsigned N_BYTES = CNT_W / DATA_W;

  ctrl_lo_t         lo_q;
  ctrl_hi_t         hi_q;
  logic [CNT_W-1:0] cmp_q, cap_q, cnt;
  logic             tmr_flag_q, cap_flag_q;
  logic             ext_rise, ext_fall_unused, pin_rise, pin_fall;
  logic             src_tick, cnt_tick, clr_pulse, match, cap_ev, mode_ok;
  logic             wr_lo, wr_hi, wr_flags;

  assign wr_lo     = we_i && addr_i == A_CTRL_LO;
  assign wr_hi     = we_i && addr_i == A_CTRL_HI;
  assign wr_flags  = we_i && addr_i == A_CNT_LO;
  assign clr_pulse = wr_lo && wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_lo) lo_q <= '{run: wdata_i[4], clk_sel: wdata_i[2:0]};
      if (wr_hi) hi_q <= '{edge_sel: edge_sel_e'(wdata_i[4:3]),
                           hi_sel: wdata_i[2:1], cascade: wdata_i[0]};
      for (int b = 0; b < N_BYTES; b++) begin
        if (we_i && addr_i == ADDR_W'(A_CMP_LO + b)) cmp_q[DATA_W*b +: DATA_W] <= wdata_i;
      end
    end
  end

  cap_timer16_edge #(.STAGES(SYNC_STAGES)) i_ext_edge (
    .clk_i, .rst_ni, .d_i(ext_clk_i), .rise_o(ext_rise), .fall_o(ext_fall_unused)
  );

  cap_timer16_edge #(.STAGES(SYNC_STAGES)) i_pin_edge (
    .clk_i, .rst_ni, .d_i(int_pin_i), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  cap_timer16_clksel #(.DIV_W(DIV_W)) i_clksel (
    .clk_i, .rst_ni, .sel_i(lo_q.clk_sel), .ext_rise_i(ext_rise), .tick_o(src_tick)
  );

  // 16-bit mode needs cascade enable and both high-half select bits
  assign mode_ok  = hi_q.cascade && (&hi_q.hi_sel);
  assign cnt_tick = src_tick && lo_q.run && mode_ok;

  cap_timer16_cnt #(.W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .clr_i(clr_pulse), .tick_i(cnt_tick), .cmp_i(cmp_q),
    .cnt_o(cnt), .match_o(match)
  );

  always_comb begin
    unique case (hi_q.edge_sel)
      EDGE_FALL: cap_ev = pin_fall;
      EDGE_RISE: cap_ev = pin_rise;
      EDGE_BOTH: cap_ev = pin_rise | pin_fall;
      default:   cap_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q      <= '0;
      tmr_flag_q <= 1'b0;
      cap_flag_q <= 1'b0;
    end else begin
      if (cap_ev) cap_q <= cnt;
      tmr_flag_q <= match  | (tmr_flag_q & ~(wr_flags & wdata_i[0]));
      cap_flag_q <= cap_ev | (cap_flag_q & ~(wr_flags & wdata_i[1]));
    end
  end

  assign tmr_irq_o = tmr_flag_q;
  assign cap_irq_o = cap_flag_q;

  always_comb begin
    unique case (addr_i)
      A_CTRL_LO: rdata_o = {3'b000, lo_q.run, 1'b0, lo_q.clk_sel};
      A_CTRL_HI: rdata_o = {3'b000, hi_q};
      A_CMP_LO:  rdata_o = cmp_q[DATA_W-1:0];
      A_CMP_HI:  rdata_o = cmp_q[CNT_W-1:DATA_W];
      A_CAP_LO:  rdata_o = cap_q[DATA_W-1:0];
      A_CAP_HI:  rdata_o = cap_q[CNT_W-1:DATA_W];
      A_CNT_LO:  rdata_o = cnt[DATA_W-1:0];
      default:   rdata_o = cnt[CNT_W-1:DATA_W];
    endcase
  end

  p_cap_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> cap_q == $past(cnt));
  p_cap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_ev |=> $stable(cap_q));
  p_cap_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> cap_irq_o);
  p_tmr_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> tmr_irq_o);
  p_no_count_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_ok && !clr_pulse) |=> $stable(cnt));
endmodule

// File: tb/test_cap_timer16.sv
`timescale 1ns/100ps
module test_cap_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_r = 1'b0, pin_r = 1'b0;
  logic       tmr_irq, cap_irq;
  int         checks = 0, errors = 0;
  string      phase = "R1";
  bit         pin_act = 0, ext_act = 0;

  always #2.5 clk = ~clk;

  cap_timer16 i_cap_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_clk_i(ext_r), .int_pin_i(pin_r),
    .tmr_irq_o(tmr_irq), .cap_irq_o(cap_irq)
  );

  // behavioural reference model
  int m_div, m_cnt, m_cmp, m_cap, m_sel, m_edge, m_hisel;
  bit m_run, m_cas, m_tf, m_cf;
  bit e1, e2, e3, p1, p2, p3;

  function automatic int log_of(int s);
    case (s)
      0: return 1; 1: return 2; 2: return 3; 3: return 5;
      4: return 7; 5: return 9; default: return 11;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_cmp = 0; m_cap = 0; m_sel = 0; m_edge = 0; m_hisel = 0;
      m_run = 0; m_cas = 0; m_tf = 0; m_cf = 0;
      e1 = 0; e2 = 0; e3 = 0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      bit tick, ctick, clr, match, ev, rise, fall;
      int k;
      k = log_of(m_sel);
      if (m_sel == 7) tick = e2 && !e3;
      else            tick = (m_div % (1 << k)) == ((1 << k) - 1);
      ctick = tick && m_run && m_cas && (m_hisel == 3);
      clr   = we && addr == 0 && wdata[3];
      match = ctick && !clr && (m_cnt == m_cmp);
      rise  = p2 && !p3;
      fall  = !p2 && p3;
      ev    = (m_edge == 0 && fall) || (m_edge == 1 && rise) || (m_edge == 2 && (rise || fall));
      if (ev) m_cap = m_cnt;
      m_tf = match || (m_tf && !(we && addr == 6 && wdata[0]));
      m_cf = ev    || (m_cf && !(we && addr == 6 && wdata[1]));
      if (clr)        m_cnt = 0;
      else if (ctick) m_cnt = (m_cnt == m_cmp) ? 0 : (m_cnt + 1) % 65536;
      m_div = (m_div + 1) % 2048;
      e3 = e2; e2 = e1; e1 = ext_r;
      p3 = p2; p2 = p1; p1 = pin_r;
      if (we) begin
        case (addr)
          0: begin m_run = wdata[4]; m_sel = wdata[2:0]; end
          1: begin m_cas = wdata[0]; m_hisel = wdata[2:1]; m_edge = wdata[4:3]; end
          2: m_cmp = (m_cmp & 16'hFF00) | wdata;
          3: m_cmp = (m_cmp & 16'h00FF) | (int'(wdata) << 8);
          default: ;
        endcase
      end
    end
  end

  function automatic int model_read(int a);
    case (a)
      0: return (int'(m_run) << 4) | m_sel;
      1: return (m_edge << 3) | (m_hisel << 1) | int'(m_cas);
      2: return m_cmp & 8'hFF;
      3: return m_cmp >> 8;
      4: return m_cap & 8'hFF;
      5: return m_cap >> 8;
      6: return m_cnt & 8'hFF;
      default: return m_cnt >> 8;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a <= 3) return "R8";
    if (a <= 5) return "R5";
    return "R2";
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (phase %s) %s: actual=%0h expected=%0h at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  // compare at every falling edge; inputs move 1 ns later
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6", int'(tmr_irq), int'(m_tf), "tmr_irq_o");
      check("R7", int'(cap_irq), int'(m_cf), "cap_irq_o");
      if (!we) check(tag_of(addr), int'(rdata), model_read(addr), $sformatf("rdata addr %0d", addr));
    end
  end

  int cyc = 0;
  task automatic step();
    @(negedge clk); #1;
    we = 1'b0;
    addr = 3'(cyc % 8);
    cyc++;
    if (pin_act && ($urandom % 5 == 0)) pin_r = ~pin_r;
    if (ext_act && (cyc % 3 == 0)) ext_r = ~ext_r;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    phase = "R1"; idle(16);
    // writes to read-only addresses: no effect
    phase = "R8"; wr(4, 8'hAA); wr(5, 8'h55); wr(7, 8'hFF); idle(8);
    // counting disabled: run without mode bits
    phase = "R2"; wr(0, 8'h10); wr(1, 8'h01); idle(40); wr(1, 8'h05); idle(40);
    // full 16-bit run, compare above 0xFF, rising capture
    phase = "R6"; wr(2, 8'h05); wr(3, 8'h01); wr(1, 8'h0F);
    pin_act = 1; idle(1200);
    phase = "R7"; wr(6, 8'h03); idle(20);
    phase = "R5";
    wr(1, 8'h07); idle(300);  // falling
    wr(1, 8'h17); idle(300);  // both
    wr(1, 8'h1F); wr(6, 8'h02); idle(300);  // none
    phase = "R2"; wr(0, 8'h00); idle(100); wr(0, 8'h10); idle(50);
    phase = "R4"; wr(0, 8'h18); idle(30); wr(0, 8'h18); wr(0, 8'h18); idle(30);
    // every divider tap with a short period
    phase = "R3"; wr(3, 8'h00); wr(2, 8'h03); wr(1, 8'h17);
    for (int s = 1; s <= 6; s++) begin
      wr(0, 8'h10 | s);
      idle((1 << log_of(s)) * 5 + 20);
    end
    // external clock through synchronizer
    ext_act = 1; wr(0, 8'h17); idle(400); ext_act = 0;
    // collisions: clear-flag writes and counter clears against sets
    phase = "R7"; wr(0, 8'h10); wr(2, 8'h01);
    for (int i = 0; i < 200; i++) begin
      wr(6, 8'h03);
      if (i % 3 == 0) wr(0, 8'h18);
      step();
    end
    phase = "R4";
    for (int i = 0; i < 60; i++) begin wr(0, 8'h18); step(); end
    pin_act = 0; idle(20);
    phase = "R1"; rst_n = 1'b0; #7; rst_n = 1'b1; idle(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule